// File: doc/BRIEF.md
# Indirect Sideband Register Bridge

This block gives a host a small memory-mapped register window onto a second register space that the host cannot address directly. The host stages a target register index and, for writes, a data word, and then writes a command word. That write launches exactly one transaction on an internal sideband request/acknowledge link to a target register bank. While the transaction is in flight a busy flag reads 1. Software polls that flag. When the flag drops, the write has landed in the target, or, for a read, the fetched word is waiting in the data register.

The command word carries the operation, a destination port identifier, per-byte write enables and a request tag. A command addressed to a port other than the configured target finishes at once without reaching the bank. A control register holds an active-low reset for the hidden space and three plain storage bits for mode and bypass selects. The included target bank is parameterised in depth. Its acknowledge is stretched by a number of wait cycles taken from the `tgt_wait` pin, and the bridge holds its request until that acknowledge arrives; this is the only back-pressure on the link.

Top module: `sbb_bridge`

## Requirements
- R1: After reset the status/command window (offset 0x2100) reads 0, the data window (0x2104) reads 0, the index window (0x2108) reads 0, and the control window (0x2110) reads 0x1. Any other offset reads 0.
- R2: The command word fields are: bit 16 is the operation (1 = write, 0 = read), bits 15:8 are the port identifier, bits 7:4 are the byte enables, and bits 31:24 are a request tag. Reading the command window returns bits 31:1 of the last accepted command.
- R3: Bit 0 of the command window is a read-only busy flag. It reads 1 from the cycle after an accepted command until the transaction ends. The value the host writes to bit 0 never appears there.
- R4: A write to a matching port updates only the bytes of the indexed target register whose enable bit is set. The bytes with a clear enable bit keep their old value.
- R5: A read from a matching port leaves the full 32-bit target word in the data window when busy drops, whatever the byte enables are.
- R6: While busy is 1, host writes to the command, data and index windows are ignored. A dropped command starts no transaction.
- R7: A command whose port identifier differs from the configured target port (default 0x12) holds busy for exactly one cycle. A read then leaves 0 in the data window, and a write changes no target register.
- R8: The sideband request stays high until the acknowledge arrives. Busy drops in the cycle after the acknowledge, so a matching transaction keeps busy high for 2 + `tgt_wait` cycles.
- R9: Writing control bit 0 as 0 clears every target register to 0 for as long as the bit stays 0. Control bits 3:1 are storage that reads back as written.
- R10: Every transaction ends within 2^WAITW + 2 cycles, which is far below the host's 100 µs polling limit at any clock above 1 MHz.
- R11: The index window stores only the low log2(NREG) bits of a host write, and those bits select the target register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe for the addressed window |
| hst_addr | input | 16 | Host window byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr (combinational) |
| tgt_wait | input | 4 | Wait cycles the target bank inserts before acknowledging |

## Verification
Random streams of reads and writes run against a bench model of the bank. The byte-enable patterns are random and include all-clear and all-set, and the wait counts are random. The model separates byte merging from whole-word updates, and each busy length is checked against 2 + wait, which exposes an off-by-one in the handshake. A fraction of the commands carry a foreign port identifier, which separates the one-cycle completion with zero data from a real bank access. Directed cases issue commands and staging writes in the middle of a long transaction to show they are dropped. Other directed cases toggle the control reset bit to show the bank clears while the storage bits survive.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int CMD_W        = 32;
  localparam int CMD_OP_BIT   = 16;
  localparam int CMD_PORT_LSB = 8;
  localparam int CMD_PORT_W   = 8;
  localparam int CMD_BE_LSB   = 4;
  localparam int CMD_BE_W     = 4;
  localparam int CMD_TAG_LSB  = 24;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_REQ  = 2'd1,
    ENG_MISS = 2'd2
  } eng_state_t;

  typedef enum logic [1:0] {
    TGT_IDLE = 2'd0,
    TGT_WAIT = 2'd1,
    TGT_ACK  = 2'd2
  } tgt_state_t;
endpackage

// File: rtl/sbb_host_regs.sv
module sbb_host_regs
  import sbb_pkg::*;
#(
  parameter int HAW       = 16,
  parameter int DW        = 32,
  parameter int TAW       = 4,
  parameter int CTRLW     = 4,
  parameter logic [HAW-1:0] OFF_CMD  = 16'h2100,
  parameter logic [HAW-1:0] OFF_DATA = 16'h2104,
  parameter logic [HAW-1:0] OFF_IDX  = 16'h2108,
  parameter logic [HAW-1:0] OFF_CTRL = 16'h2110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_we,
  input  logic [HAW-1:0]   hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  input  logic             busy,
  input  logic             ld_en,
  input  logic [DW-1:0]    ld_val,
  output logic             start,
  output logic [DW-1:0]    cmd_q,
  output logic [DW-1:0]    data_q,
  output logic [TAW-1:0]   idx_q,
  output logic [CTRLW-1:0] ctrl_q
);
  logic wr_cmd, wr_data, wr_idx, wr_ctrl;

  assign wr_cmd  = hst_we && (hst_addr == OFF_CMD);
  assign wr_data = hst_we && (hst_addr == OFF_DATA);
  assign wr_idx  = hst_we && (hst_addr == OFF_IDX);
  assign wr_ctrl = hst_we && (hst_addr == OFF_CTRL);

  // a command launches only when the engine is idle
  assign start = wr_cmd && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (start) begin
      cmd_q <= {hst_wdata[DW-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (ld_en) begin
      data_q <= ld_val;
    end else if (wr_data && !busy) begin
      data_q <= hst_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr_idx && !busy) begin
      idx_q <= hst_wdata[TAW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRLW'(1);
    end else if (wr_ctrl) begin
      ctrl_q <= hst_wdata[CTRLW-1:0];
    end
  end

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFF_CMD:  hst_rdata = {cmd_q[DW-1:1], busy};
      OFF_DATA: hst_rdata = data_q;
      OFF_IDX:  hst_rdata = DW'(idx_q);
      OFF_CTRL: hst_rdata = DW'(ctrl_q);
      default:  hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sbb_engine.sv
module sbb_engine
  import sbb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PORTW = 8,
  parameter logic [PORTW-1:0] PORT_ID = 8'h12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PORTW-1:0] start_port,
  input  logic             start_wr,
  input  logic             sb_ack,
  input  logic [DW-1:0]    sb_rdata,
  output logic             busy,
  output logic             sb_req,
  output logic             sb_we,
  output logic             ld_en,
  output logic [DW-1:0]    ld_val
);
  eng_state_t state_q;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start) begin
          wr_q    <= start_wr;
          state_q <= (start_port == PORT_ID) ? ENG_REQ : ENG_MISS;
        end
        ENG_REQ:  if (sb_ack) state_q <= ENG_IDLE;
        ENG_MISS: state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ENG_IDLE);
  assign sb_req = (state_q == ENG_REQ);
  assign sb_we  = wr_q;

  // reads refill the data window on completion; misses return zero
  assign ld_en  = !wr_q && (((state_q == ENG_REQ) && sb_ack) || (state_q == ENG_MISS));
  assign ld_val = (state_q == ENG_REQ) ? sb_rdata : '0;
endmodule

// File: rtl/sbb_target_bank.sv
module sbb_target_bank
  import sbb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int WAITW = 4,
  localparam int IDXW = $clog2(NREG),
  localparam int BEW  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             space_rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [IDXW-1:0]  idx,
  input  logic [DW-1:0]    wdata,
  input  logic [BEW-1:0]   be,
  input  logic [WAITW-1:0] wait_cycles,
  output logic             ack,
  output logic [DW-1:0]    rdata
);
  tgt_state_t             st_q;
  logic [WAITW-1:0]       cnt_q;
  logic                   fire;
  logic [NREG-1:0][DW-1:0] words;

  assign fire = ((st_q == TGT_IDLE) && req && (wait_cycles == '0)) ||
                ((st_q == TGT_WAIT) && (cnt_q == WAITW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TGT_IDLE;
      cnt_q <= '0;
      ack   <= 1'b0;
    end else begin
      case (st_q)
        TGT_IDLE: if (req) begin
          if (wait_cycles == '0) begin
            ack  <= 1'b1;
            st_q <= TGT_ACK;
          end else begin
            cnt_q <= wait_cycles;
            st_q  <= TGT_WAIT;
          end
        end
        TGT_WAIT: begin
          if (cnt_q == WAITW'(1)) begin
            ack  <= 1'b1;
            st_q <= TGT_ACK;
          end else begin
            cnt_q <= cnt_q - WAITW'(1);
          end
        end
        TGT_ACK: begin
          ack  <= 1'b0;
          st_q <= TGT_IDLE;
        end
        default: st_q <= TGT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (fire) begin
      rdata <= words[idx];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n || !space_rst_n) begin
        word_q <= '0;
      end else if (fire && we && (idx == IDXW'(r))) begin
        for (int b = 0; b < BEW; b++) begin
          if (be[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
    assign words[r] = word_q;
  end
endmodule

// File: rtl/sbb_bridge.sv
module sbb_bridge
  import sbb_pkg::*;
#(
  parameter int HAW   = 16,
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int WAITW = 4,
  parameter logic [7:0] PORT_ID = 8'h12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_we,
  input  logic [HAW-1:0]   hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  input  logic [WAITW-1:0] tgt_wait
);
  localparam int IDXW  = $clog2(NREG);
  localparam int CTRLW = 4;

  logic             busy, start, ld_en;
  logic [DW-1:0]    ld_val, cmd_q, data_q, sb_rdata;
  logic [IDXW-1:0]  idx_q;
  logic [CTRLW-1:0] ctrl_q;
  logic             sb_req, sb_we, sb_ack;

  sbb_host_regs #(
    .HAW(HAW), .DW(DW), .TAW(IDXW), .CTRLW(CTRLW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .busy(busy),
    .ld_en(ld_en), .ld_val(ld_val), .start(start), .cmd_q(cmd_q),
    .data_q(data_q), .idx_q(idx_q), .ctrl_q(ctrl_q)
  );

  sbb_engine #(
    .DW(DW), .PORTW(CMD_PORT_W), .PORT_ID(PORT_ID)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_port(hst_wdata[CMD_PORT_LSB +: CMD_PORT_W]),
    .start_wr(hst_wdata[CMD_OP_BIT]),
    .sb_ack(sb_ack), .sb_rdata(sb_rdata), .busy(busy),
    .sb_req(sb_req), .sb_we(sb_we), .ld_en(ld_en), .ld_val(ld_val)
  );

  sbb_target_bank #(
    .DW(DW), .NREG(NREG), .WAITW(WAITW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .space_rst_n(ctrl_q[0]),
    .req(sb_req), .we(sb_we), .idx(idx_q), .wdata(data_q),
    .be(cmd_q[CMD_BE_LSB +: CMD_BE_W]), .wait_cycles(tgt_wait),
    .ack(sb_ack), .rdata(sb_rdata)
  );
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int WAITW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sb_req,
  input logic sb_ack
);
  localparam int LIMIT = (1 << WAITW) + 2;
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else run_q <= 0;
  end

  assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req |-> busy);
  assert_ack_inside_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ack |-> sb_req);
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack) |=> sb_req);
  assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ack |=> !busy);
  assert_busy_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);
endmodule

bind sbb_bridge sbb_checker #(.WAITW(WAITW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sb_req(sb_req), .sb_ack(sb_ack)
);

// File: tb/tb_sbb_bridge.sv
module tb_sbb_bridge;
  localparam logic [15:0] A_CMD = 16'h2100, A_DATA = 16'h2104,
                          A_IDX = 16'h2108, A_CTRL = 16'h2110;
  localparam logic [7:0] PID = 8'h12;

  logic clk = 0, rst_n = 0, hst_we = 0;
  logic [15:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic [3:0]  tgt_wait = '0;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  sbb_bridge dut (.clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
                  .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .tgt_wait(tgt_wait));

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mk_cmd(logic [7:0] tag, logic wr, logic [7:0] port,
                                         logic [3:0] be);
    return {tag, 7'd0, wr, port, be, 4'b0001};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [31:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0; hst_addr = A_CMD; #1;
    while (hst_rdata[0] && cnt < 100) begin
      cnt++; @(negedge clk); #1;
    end
  endtask

  task automatic txn(input int idx, input logic wr, input logic [3:0] be,
                     input logic [31:0] d, input logic [7:0] port, input int w);
    int cnt; logic [31:0] got, exp; bit ok_port;
    ok_port = (port == PID);
    tgt_wait = 4'(w);
    hwr(A_DATA, d); hwr(A_IDX, 32'(idx));
    hwr(A_CMD, mk_cmd(8'(idx), wr, port, be));
    wait_idle(cnt);
    check(cnt == (ok_port ? 2 + w : 1), "R8/R7 busy length", 32'(cnt),
          32'(ok_port ? 2 + w : 1));
    hrd(A_DATA, got);
    if (wr) begin
      if (ok_port) model[idx] = merge(model[idx], d, be);
      exp = d;
    end else begin
      exp = ok_port ? model[idx] : 32'h0;
    end
    check(got == exp, wr ? "R4 data window kept" : (ok_port ? "R5 read word" : "R7 miss read zero"),
          got, exp);
  endtask

  task automatic read_back(input int idx, input string req);
    logic [31:0] got;
    int cnt;
    tgt_wait = 0;
    hwr(A_IDX, 32'(idx));
    hwr(A_CMD, mk_cmd(8'h00, 1'b0, PID, 4'h0));
    wait_idle(cnt);
    hrd(A_DATA, got);
    check(got == model[idx], req, got, model[idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'd7741));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    hrd(A_CMD, v);  check(v == 0, "R1 cmd reset", v, 0);
    hrd(A_DATA, v); check(v == 0, "R1 data reset", v, 0);
    hrd(A_IDX, v);  check(v == 0, "R1 index reset", v, 0);
    hrd(A_CTRL, v); check(v == 1, "R1 ctrl reset", v, 1);
    hrd(16'h2118, v); check(v == 0, "R1 unmapped", v, 0);

    // R4 partial byte write, R5 read ignores byte enables
    txn(2, 1'b1, 4'hF, 32'hA1B2C3D4, PID, 0);
    txn(2, 1'b1, 4'b0101, 32'h11223344, PID, 1);
    txn(2, 1'b0, 4'h0, 32'h0, PID, 3);
    check(model[2] == 32'hA122C344, "R4 merge model", model[2], 32'hA122C344);

    // R2/R3 command readback, busy flag set then clear, written bit0 not kept
    tgt_wait = 4'd5;
    hwr(A_CMD, mk_cmd(8'h5A, 1'b0, PID, 4'h3));
    hrd(A_CMD, v);
    check(v[0] == 1'b1, "R3 busy during txn", 32'(v[0]), 1);
    wait_idle(cnt);
    hrd(A_CMD, v);
    check(v == {8'h5A, 7'd0, 1'b0, PID, 4'h3, 4'h0}, "R2 R3 cmd readback", v,
          {8'h5A, 7'd0, 1'b0, PID, 4'h3, 4'h0});

    // R6 writes while busy dropped
    tgt_wait = 4'd12;
    hwr(A_DATA, 32'hCAFEF00D); hwr(A_IDX, 32'd3);
    hwr(A_CMD, mk_cmd(8'h33, 1'b1, PID, 4'hF));
    hwr(A_DATA, 32'h0BADBEEF);
    hwr(A_IDX, 32'd5);
    hwr(A_CMD, mk_cmd(8'h77, 1'b0, PID, 4'hF));
    wait_idle(cnt);
    model[3] = 32'hCAFEF00D;
    hrd(A_DATA, v); check(v == 32'hCAFEF00D, "R6 data kept", v, 32'hCAFEF00D);
    hrd(A_IDX, v);  check(v == 3, "R6 index kept", v, 3);
    hrd(A_CMD, v);  check(v[31:24] == 8'h33 && v[0] == 0, "R6 cmd kept, no second txn", v,
                          {8'h33, 24'h0});
    read_back(3, "R6 first write landed");
    read_back(5, "R6 dropped cmd no effect");

    // R7 foreign port
    txn(4, 1'b1, 4'hF, 32'h55AA55AA, 8'h13, 2);
    read_back(4, "R7 miss write no effect");
    hwr(A_DATA, 32'hFFFFFFFF);
    txn(3, 1'b0, 4'hF, 32'h12345678, 8'h00, 0);

    // R11 index truncation
    txn(19 & 15, 1'b1, 4'hF, 32'h0000BEEF, PID, 0);
    hwr(A_IDX, 32'h00000013);
    hrd(A_IDX, v); check(v == 32'h3, "R11 index low bits", v, 3);

    // R10 longest wait
    txn(7, 1'b1, 4'hF, 32'h77777777, PID, 15);

    // random mix (R4 R5 R7 R8)
    for (int i = 0; i < 300; i++) begin
      logic [7:0] p;
      p = ($urandom % 8 == 0) ? 8'($urandom) : PID;
      txn(int'($urandom % 16), 1'($urandom), 4'($urandom), $urandom, p,
          int'($urandom % 8));
    end

    // R9 sideband space reset and storage bits
    hwr(A_CTRL, 32'h0000000E);
    hrd(A_CTRL, v); check(v == 32'hE, "R9 ctrl storage", v, 32'hE);
    hwr(A_CTRL, 32'h0000000F);
    hrd(A_CTRL, v); check(v == 32'hF, "R9 ctrl release", v, 32'hF);
    for (int i = 0; i < 16; i++) model[i] = '0;
    for (int i = 0; i < 16; i++) read_back(i, "R9 bank cleared");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule